// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block protects a data word on a shared bus with a single parity bit. It sits between a nine-line data path and one bidirectional parity wire. When the block sends, it works out a parity bit over the data lines and drives that bit onto the wire. When it receives, it lets go of the wire, takes the parity bit that arrives from the far end, and pulls an active-low error flag low if the data and the parity together break the parity rule. The scheme is odd overall: the data lines plus the parity bit must carry an odd number of ones.

The wire appears as three signals: a value to drive, an output enable, and the value seen on the wire. A power-good input keeps the driver off and the error flag quiet while the supply is not valid, so the bus does not glitch during ramp-up or ramp-down. A chain input counts as one extra data line, so that several units can cover a wider word. Tied low, the chain input leaves a single unit with its plain nine-line behaviour. To cascade, connect a downstream unit's chain input to the inverted parity output of the unit before it.

Top module: `bus_parity_port`

## Requirements
- R1: parity_oe is high exactly when xmit is low and power_good is high.
- R2: parity_out is high when the number of ones across data and chain_in is even (0, 2, 4, 6, 8, ...), and low when that number is odd.
- R3: While xmit is low (send mode), err_n is high for every data and parity_in value.
- R4: While xmit and power_good are both high (check mode), err_n is high when data, chain_in and parity_in together hold an odd number of ones, and low when they hold an even number.
- R5: While power_good is low, parity_oe is low and err_n is high, whatever xmit, data and parity_in are.
- R6: With chain_in at 0, the block follows the plain nine-line rules. Setting chain_in to 1 inverts parity_out, and in check mode it inverts err_n, exactly as one more high data line would.
- R7: Two units cascade into an 18-bit check. The lower unit's chain_in is taken from the inverted parity_out of the upper unit, which stays in send mode. The lower unit's err_n then reports whether all 18 data bits plus parity_in hold an odd number of ones.
- R8: In send mode, parity_in has no effect on parity_out, parity_oe or err_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data | input | DATA_W | Data lines covered by the parity bit |
| chain_in | input | 1 | Cascade term, counted as one extra data line; tie to 0 when unused |
| xmit | input | 1 | 0 = send (drive the parity wire), 1 = check (receive from the wire) |
| power_good | input | 1 | Supply valid; low forces the driver off and the error flag inactive |
| parity_in | input | 1 | Value seen on the parity wire |
| parity_out | output | 1 | Generated parity bit to drive onto the wire |
| parity_oe | output | 1 | Output enable for the parity wire driver |
| err_n | output | 1 | Active-low parity error flag |

## Verification
The bench builds the block with the default DATA_W of 9. That default makes it practical to apply all 512 data patterns in send mode and in check mode, with both wire values in each, and to compare every result with a population count. A second nine-bit instance sits upstream and feeds the chain input. With that pair, the bench checks 18-bit cascaded words across both halves of the data, and it checks the inverting effect of the chain term on its own.

// File: rtl/bus_parity_port.sv
module bus_parity_port #(
  parameter int DATA_W = 9
) (
  input  logic [DATA_W-1:0] data,
  input  logic              chain_in,
  input  logic              xmit,
  input  logic              power_good,
  input  logic              parity_in,
  output logic              parity_out,
  output logic              parity_oe,
  output logic              err_n
);

  localparam int TERMS = DATA_W + 1;

  logic [TERMS-1:0] terms;
  logic             word_odd;
  logic             check_en;
  logic             total_odd;

  assign terms     = {chain_in, data};
  assign word_odd  = ^terms;
  assign check_en  = xmit & power_good;
  assign total_odd = word_odd ^ parity_in;

  assign parity_out = ~word_odd;
  assign parity_oe  = ~xmit & power_good;
  assign err_n      = ~(check_en & ~total_odd);

  always_comb begin
    p_drive_vs_flag_r3: assert (!(parity_oe && !err_n))
      else $error("driver and error flag active together");
    p_oe_only_send_r1: assert (!parity_oe || !xmit)
      else $error("driver enabled in check mode");
    p_power_quiet_r5: assert (power_good || (!parity_oe && err_n))
      else $error("outputs active without power");
    if (check_en) begin
      p_check_match_r4: assert (err_n == (parity_in == parity_out))
        else $error("error flag disagrees with regenerated parity");
    end
  end

endmodule

// File: tb/test_bus_parity_port.sv
module test_bus_parity_port;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 9;

  typedef struct packed {
    logic exp_out;
    logic exp_oe;
    logic exp_err;
    logic [3:0] tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] data = '0;
  logic [DW-1:0] up_data = '0;
  logic chain_drv = 1'b0;
  logic use_chain = 1'b0;
  logic xmit = 1'b0;
  logic pg_drv = 1'b1;
  logic pin = 1'b0;
  logic power_good;
  logic chain_in;
  logic parity_out, parity_oe, err_n;
  logic up_out, up_oe, up_err;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign power_good = pg_drv & ~rst;
  assign chain_in = use_chain ? ~up_out : chain_drv;

  bus_parity_port #(.DATA_W(DW)) u_upstream (
    .data(up_data), .chain_in(1'b0), .xmit(1'b0), .power_good(1'b1),
    .parity_in(1'b0), .parity_out(up_out), .parity_oe(up_oe), .err_n(up_err)
  );

  bus_parity_port #(.DATA_W(DW)) i_bus_parity_port (
    .data(data), .chain_in(chain_in), .xmit(xmit), .power_good(power_good),
    .parity_in(pin), .parity_out(parity_out), .parity_oe(parity_oe), .err_n(err_n)
  );

  task automatic apply(input logic [DW-1:0] d, input logic [DW-1:0] ud,
                       input logic c, input logic uc, input logic x,
                       input logic pg, input logic p, input logic [3:0] tag);
    item_t it;
    int ones;
    @(posedge clk);
    data = d; up_data = ud; chain_drv = c; use_chain = uc;
    xmit = x; pg_drv = pg; pin = p;
    ones = $countones(d) + (uc ? $countones(ud) : int'(c));
    it.exp_out = (ones % 2 == 0);
    it.exp_oe  = !x && pg && !rst;
    it.exp_err = !(x && pg && !rst && ((ones + int'(p)) % 2 == 0));
    it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (!it.exp_oe && !(!rst && pg_drv && !xmit) && parity_oe !== it.exp_oe) begin
        fails++;
        $display("FAIL R1/R5 tag %0d: parity_oe=%b expected %b", it.tag, parity_oe, it.exp_oe);
      end else if (parity_oe !== it.exp_oe) begin
        fails++;
        $display("FAIL R1 tag %0d: parity_oe=%b expected %b", it.tag, parity_oe, it.exp_oe);
      end else if (!use_chain && parity_out !== it.exp_out) begin
        fails++;
        $display("FAIL R2/R6 tag %0d: parity_out=%b expected %b", it.tag, parity_out, it.exp_out);
      end else if (err_n !== it.exp_err) begin
        fails++;
        if (use_chain)
          $display("FAIL R7 tag %0d: err_n=%b expected %b", it.tag, err_n, it.exp_err);
        else if (!xmit)
          $display("FAIL R3/R8 tag %0d: err_n=%b expected %b", it.tag, err_n, it.exp_err);
        else
          $display("FAIL R4/R5 tag %0d: err_n=%b expected %b", it.tag, err_n, it.exp_err);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: expired, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // reset state: power held off, R5
    apply('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0);
    apply('1, '0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0);
    @(posedge clk); rst = 1'b0;
    // R1 R2 R3 R8: send mode, every pattern, both wire values
    for (int d = 0; d < 512; d++)
      for (int p = 0; p < 2; p++)
        apply(DW'(d), '0, 1'b0, 1'b0, 1'b0, 1'b1, p[0], 4'd1);
    // R4: check mode, every pattern, both wire values
    for (int d = 0; d < 512; d++)
      for (int p = 0; p < 2; p++)
        apply(DW'(d), '0, 1'b0, 1'b0, 1'b1, 1'b1, p[0], 4'd2);
    // R6: chain term set in both modes
    for (int d = 0; d < 512; d += 7)
      for (int x = 0; x < 2; x++)
        for (int p = 0; p < 2; p++)
          apply(DW'(d), '0, 1'b1, 1'b0, x[0], 1'b1, p[0], 4'd3);
    // R5: power lost in both modes
    for (int d = 0; d < 512; d += 13)
      for (int x = 0; x < 2; x++)
        for (int p = 0; p < 2; p++)
          apply(DW'(d), '0, d[0], 1'b0, x[0], 1'b0, p[0], 4'd4);
    // R7: 18-bit cascade through upstream unit
    for (int u = 0; u < 512; u += 5)
      for (int d = 0; d < 512; d += 37)
        for (int p = 0; p < 2; p++)
          apply(DW'(d), DW'(u), 1'b0, 1'b1, 1'b1, 1'b1, p[0], 4'd5);
    apply('1, '1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd5);
    apply('1, '1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd5);
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule